// File: doc/BRIEF.md
# Iterative Integer Multiplier with Selectable High-Half Signedness

This block is the multiply half of a register-to-register arithmetic unit in a small integer core. The issue stage gives it two 32-bit source values, the opcode, funct7 and funct3 fields of the instruction and the destination register index, and raises a start strobe for one cycle. The unit checks for itself that the fields name one of the four multiply operations. If they do, it runs a shift-and-add loop that retires a fixed number of multiplier bits per cycle. After a fixed latency it raises a one-cycle done flag. In that cycle the 32-bit result and a write-enable for the register file are valid.

Every operation uses one unsigned magnitude datapath. Before the loop starts, each operand that the selected operation treats as signed is replaced by its absolute value, and the sign of the product is recorded. When the loop ends, the 64-bit magnitude is negated when that recorded sign is set, and then either the lower or the upper word is returned. The loop therefore never sees signed data. The same array gives the low word, the signed-by-signed high word, the signed-by-unsigned high word and the unsigned-by-unsigned high word.

The unit holds one operation at a time. The issue logic has to wait for done before it starts the next one. A start that arrives earlier is dropped.

Top module: `mulx_unit`

## Requirements
- R1: A start is accepted only when opcode equals 7'b0110011, funct7 equals 7'b0000001 and funct3 bit 2 is 0. Any other combination produces no done pulse.
- R2: funct3 3'b000 returns bits [31:0] of the product of the two operands. This value does not depend on signedness.
- R3: funct3 3'b001 treats both operands as two's-complement signed values and returns bits [63:32] of their 64-bit product.
- R4: funct3 3'b010 treats operand A as signed and operand B as unsigned, and returns bits [63:32] of the 64-bit product.
- R5: funct3 3'b011 treats both operands as unsigned and returns bits [63:32] of the 64-bit product.
- R6: The write-enable output is high only in the done cycle, and only when the captured destination index is not zero. For index 0 it stays low.
- R7: An accepted start on clock edge E0 makes done high for exactly one cycle, beginning after edge E0+XLEN/STEP_BITS. With the default parameters this is 8 cycles.
- R8: A start that arrives while an operation is in progress is ignored. The running operation completes with its original result and latency, and no extra done pulse follows.
- R9: While reset is asserted, and in the first cycle after it is released, done and write-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| opcode_i | input | 7 | Instruction opcode field |
| funct7_i | input | 7 | Instruction funct7 field |
| funct3_i | input | 3 | Operation selector |
| rd_i | input | 5 | Destination register index |
| op_a_i | input | XLEN | First source operand |
| op_b_i | input | XLEN | Second source operand |
| result_o | output | XLEN | Selected word of the product, valid while done is high |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Register-file write enable for the result |

## Verification
If the step counter or the busy state is wrong, the first thing to show it is the done pulse. It arrives early or late, it lasts more than one cycle, or a second pulse appears after a start that should have been ignored. All of these are visible within one latency period of the start. A wrong captured sign or a wrong operation select does not move the done pulse. It only corrupts result_o, so the bench sets the signed corner operands against each other under every operation, where an error in sign handling changes the upper word. A shift or carry fault inside the loop also shows up on result_o in that same done cycle.

// File: rtl/mulx_pkg.sv
// Shared types and field codes of the multiply unit.
// Assumes the standard 32-bit register-register instruction layout.
package mulx_pkg;

    // Opcode and funct7 values that mark the multiply/divide group.
    localparam logic [6:0] OPC_REG_ARITH = 7'b0110011;
    localparam logic [6:0] F7_MULDIV     = 7'b0000001;

    // Internal operation kind, taken from funct3[1:0] once a multiply is known.
    typedef enum logic [1:0] {
        MK_LOW  = 2'b00,   // low word, signedness does not matter
        MK_HSS  = 2'b01,   // high word, signed x signed
        MK_HSU  = 2'b10,   // high word, signed x unsigned
        MK_HUU  = 2'b11    // high word, unsigned x unsigned
    } mul_kind_e;

endpackage

// File: rtl/mulx_decode.sv
// Field decoder: finds out whether the presented fields name a multiply
// and which of the four kinds it is. Purely combinational.
// Assumes funct3[2]=1 is the divide group, which is handled elsewhere.
module mulx_decode
    import mulx_pkg::*;
(
    input  logic [6:0] opcode_i,
    input  logic [6:0] funct7_i,
    input  logic [2:0] funct3_i,
    input  logic [4:0] rd_i,
    output logic       is_mul_o,
    output mul_kind_e  kind_o,
    output logic       rd_nz_o
);

    // Classify the request and pick the operation kind.
    always_comb begin
        is_mul_o = (opcode_i == OPC_REG_ARITH) && (funct7_i == F7_MULDIV) && !funct3_i[2];
        kind_o   = mul_kind_e'(funct3_i[1:0]);
        rd_nz_o  = (rd_i != 5'd0);
    end

endmodule

// File: rtl/mulx_sign_prep.sv
// Operand conditioning: for each operand that the kind treats as signed,
// replaces it with its absolute value and records the sign of the product.
// Assumes the most negative value keeps its bit pattern, which is the
// correct unsigned magnitude (2^(W-1)).
module mulx_sign_prep
    import mulx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  mul_kind_e    kind_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_o
);

    logic a_signed, b_signed, a_neg, b_neg;

    // Decide the signedness of each operand from the kind.
    always_comb begin
        a_signed = (kind_i == MK_HSS) || (kind_i == MK_HSU);
        b_signed = (kind_i == MK_HSS);
        a_neg    = a_signed && a_i[W-1];
        b_neg    = b_signed && b_i[W-1];
    end

    // Form the magnitudes and the sign of the product.
    always_comb begin
        mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
        neg_o   = a_neg ^ b_neg;
    end

endmodule

// File: rtl/mulx_shift_core.sv
// Unsigned shift-and-add multiplier. Each step retires STEP bits of the
// multiplier, and after W/STEP steps prod_o holds the full 2W-bit product.
// Assumes W is a multiple of STEP and STEP < W.
module mulx_shift_core #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] prod_o
);

    localparam int SW = W + STEP;

    logic [2*W-1:0] prod_q;
    logic [W-1:0]   mcand_q;
    logic [SW-1:0]  term [STEP];
    logic [SW-1:0]  upper_sum;
    logic [2*W-1:0] prod_next;

    // One shifted copy of the multiplicand for each multiplier bit of a step.
    for (genvar j = 0; j < STEP; j++) begin : g_term
        assign term[j] = prod_q[j] ? ({{STEP{1'b0}}, mcand_q} << j) : '0;
    end

    // Add the partial products to the upper word, then shift right by STEP.
    always_comb begin
        upper_sum = {{STEP{1'b0}}, prod_q[2*W-1:W]};
        for (int j = 0; j < STEP; j++) begin
            upper_sum = upper_sum + term[j];
        end
        prod_next = {upper_sum, prod_q[W-1:STEP]};
    end

    // Load the operands or advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
        end else if (load_i) begin
            prod_q  <= {{W{1'b0}}, mplier_i};
            mcand_q <= mcand_i;
        end else if (step_i) begin
            prod_q  <= prod_next;
        end
    end

    assign prod_o = prod_q;

endmodule

// File: rtl/mulx_result_sel.sv
// Output stage: puts the recorded sign back on the unsigned product and
// returns the low or the high word, depending on the kind.
// Assumes the magnitude product fits in 2W-1 bits whenever neg_i is set.
module mulx_result_sel
    import mulx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod_i,
    input  logic           neg_i,
    input  mul_kind_e      kind_i,
    output logic [W-1:0]   result_o
);

    logic [2*W-1:0] signed_prod;

    // Apply the sign correction and select the word.
    always_comb begin
        signed_prod = neg_i ? (~prod_i + 1'b1) : prod_i;
        result_o    = (kind_i == MK_LOW) ? signed_prod[W-1:0] : signed_prod[2*W-1:W];
    end

endmodule

// File: rtl/mulx_unit.sv
// Multiply unit top: decodes the request, conditions the operands, runs the
// iterative core for XLEN/STEP_BITS cycles and pulses done with the result.
// Assumes the issuer holds off new work until done; an early start is dropped.
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int STEP_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [6:0]      opcode_i,
    input  logic [6:0]      funct7_i,
    input  logic [2:0]      funct3_i,
    input  logic [4:0]      rd_i,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    output logic [XLEN-1:0] result_o,
    output logic            done_o,
    output logic            wr_en_o
);

    localparam int ITER = XLEN / STEP_BITS;
    localparam int CW   = $clog2(ITER + 1);

    logic            is_mul, rd_nz, neg_now, accept;
    mul_kind_e       kind_now, kind_q;
    logic [XLEN-1:0] mag_a, mag_b;
    logic [2*XLEN-1:0] prod;
    logic            busy_q, neg_q, rd_nz_q, done_q, wr_q;
    logic [CW-1:0]   cnt_q;

    mulx_decode u_dec (
        .opcode_i (opcode_i),
        .funct7_i (funct7_i),
        .funct3_i (funct3_i),
        .rd_i     (rd_i),
        .is_mul_o (is_mul),
        .kind_o   (kind_now),
        .rd_nz_o  (rd_nz)
    );

    mulx_sign_prep #(.W(XLEN)) u_prep (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .kind_i  (kind_now),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .neg_o   (neg_now)
    );

    // A new operation begins only when the unit is idle.
    assign accept = start_i && is_mul && !busy_q;

    mulx_shift_core #(.W(XLEN), .STEP(STEP_BITS)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (busy_q),
        .mcand_i  (mag_a),
        .mplier_i (mag_b),
        .prod_o   (prod)
    );

    mulx_result_sel #(.W(XLEN)) u_sel (
        .prod_i   (prod),
        .neg_i    (neg_q),
        .kind_i   (kind_q),
        .result_o (result_o)
    );

    // Sequence control: capture on accept, count steps, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            kind_q  <= MK_LOW;
            neg_q   <= 1'b0;
            rd_nz_q <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                cnt_q   <= '0;
                kind_q  <= kind_now;
                neg_q   <= neg_now;
                rd_nz_q <= rd_nz;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(ITER - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    wr_q   <= rd_nz_q;
                end
            end
        end
    end

    assign done_o  = done_q;
    assign wr_en_o = wr_q;

endmodule

// File: rtl/mulx_unit_chk.sv
// Port-level checker for mulx_unit. It keeps its own record of the accepted
// request and its own latency counter, and checks done, write-enable and
// selected result values against that record.
module mulx_unit_chk #(
    parameter int XLEN = 32,
    parameter int LAT  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [6:0]      opcode_i,
    input logic [6:0]      funct7_i,
    input logic [2:0]      funct3_i,
    input logic [4:0]      rd_i,
    input logic [XLEN-1:0] op_a_i,
    input logic [XLEN-1:0] op_b_i,
    input logic [XLEN-1:0] result_o,
    input logic            done_o,
    input logic            wr_en_o
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]     cnt;
    logic [XLEN-1:0]   a_c, b_c;
    logic [2:0]        f3_c;
    logic [4:0]        rd_c;
    logic [2*XLEN-1:0] uprod;
    logic              hit;

    // Independent view of which requests count as multiplies.
    assign hit = start_i && (opcode_i == 7'b0110011) && (funct7_i == 7'b0000001) && !funct3_i[2];
    assign uprod = {{XLEN{1'b0}}, a_c} * {{XLEN{1'b0}}, b_c};

    // Track the outstanding request and its remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            a_c  <= '0;
            b_c  <= '0;
            f3_c <= '0;
            rd_c <= '0;
        end else if (cnt == '0 && hit) begin
            cnt  <= CW'(LAT);
            a_c  <= op_a_i;
            b_c  <= op_b_i;
            f3_c <= funct3_i;
            rd_c <= rd_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    p_reset_quiet_r9: assert property (@(posedge clk) !rst_n |=> (!done_o && !wr_en_o));

    p_done_on_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(1)) |=> done_o);

    p_done_only_expected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cnt) == CW'(1)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_wr_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o);

    p_wr_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_en_o == (rd_c != 5'd0)));

    p_low_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && f3_c == 3'b000) |-> (result_o == uprod[XLEN-1:0]));

    p_high_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && f3_c == 3'b011) |-> (result_o == uprod[2*XLEN-1:XLEN]));

endmodule

bind mulx_unit mulx_unit_chk #(.XLEN(XLEN), .LAT(XLEN / STEP_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .funct7_i (funct7_i),
    .funct3_i (funct3_i),
    .rd_i     (rd_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .result_o (result_o),
    .done_o   (done_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/mulx_unit_bench.sv
// Self-checking bench: every corner operand pair under every kind, random
// operands, rejected encodings and a start while busy.
module mulx_unit_bench;

    localparam int XLEN = 32;
    localparam int STEPB = 4;
    localparam int LAT = XLEN / STEPB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [6:0]      opcode_i = 7'b0110011;
    logic [6:0]      funct7_i = 7'b0000001;
    logic [2:0]      funct3_i = 3'b000;
    logic [4:0]      rd_i = 5'd1;
    logic [XLEN-1:0] op_a_i = '0;
    logic [XLEN-1:0] op_b_i = '0;
    logic [XLEN-1:0] result_o;
    logic            done_o, wr_en_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [XLEN-1:0] corners [5] = '{32'h0, 32'h1, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF};

    always #5 clk = ~clk;

    mulx_unit #(.XLEN(XLEN), .STEP_BITS(STEPB)) u_mulx_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .funct7_i(funct7_i), .funct3_i(funct3_i), .rd_i(rd_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .result_o(result_o),
        .done_o(done_o), .wr_en_o(wr_en_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference word for a kind, from 64-bit extended operands.
    function automatic logic [31:0] ref_word(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb, p;
        ea = (f3 == 3'b001 || f3 == 3'b010) ? {{32{a[31]}}, a} : {32'h0, a};
        eb = (f3 == 3'b001) ? {{32{b[31]}}, b} : {32'h0, b};
        p  = ea * eb;
        return (f3 == 3'b000) ? p[31:0] : p[63:32];
    endfunction

    function automatic string req_of(input logic [2:0] f3);
        case (f3)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            default: return "R5";
        endcase
    endfunction

    // Issue one multiply and check latency, result, write enable and pulse width.
    task automatic run_op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd);
        int k;
        @(negedge clk);
        opcode_i = 7'b0110011; funct7_i = 7'b0000001;
        funct3_i = f3; op_a_i = a; op_b_i = b; rd_i = rd; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = ~a; op_b_i = ~b;
        k = 1;
        @(posedge clk);
        @(negedge clk);
        while (!done_o && k < LAT + 4) begin
            k++;
            @(posedge clk);
            @(negedge clk);
        end
        check(k == LAT, "R7 latency", 64'(k), 64'(LAT));
        check(result_o == ref_word(f3, a, b), req_of(f3), 64'(result_o), 64'(ref_word(f3, a, b)));
        check(wr_en_o == (rd != 5'd0), "R6 write enable", 64'(wr_en_o), 64'(rd != 5'd0));
        @(posedge clk);
        @(negedge clk);
        check(!done_o && !wr_en_o, "R7 single-cycle done", 64'(done_o), 64'(0));
    endtask

    // Issue a request that must be rejected and watch for any done.
    task automatic run_reject(input logic [6:0] opc, input logic [6:0] f7, input logic [2:0] f3);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        opcode_i = opc; funct7_i = f7; funct3_i = f3;
        op_a_i = 32'd3; op_b_i = 32'd5; rd_i = 5'd4; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < LAT + 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done_o || wr_en_o) seen = 1'b1;
        end
        check(!seen, "R1 rejected encoding", 64'(seen), 64'(0));
    endtask

    initial begin
        #(2_000_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done_o && !wr_en_o, "R9 reset state", 64'({done_o, wr_en_o}), 64'(0));
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!done_o && !wr_en_o, "R9 after release", 64'({done_o, wr_en_o}), 64'(0));

        // Every corner pair under every kind; rd cycles so index 0 appears (R6).
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run_op(3'(f), corners[i], corners[j], 5'((i * 5 + j + f) % 4));

        // Random operands for each kind.
        for (int f = 0; f < 4; f++)
            for (int n = 0; n < 40; n++)
                run_op(3'(f), $urandom, $urandom, 5'($urandom));

        // R1: wrong opcode, wrong funct7, divide-group funct3.
        run_reject(7'b0010011, 7'b0000001, 3'b000);
        run_reject(7'b0110011, 7'b0000000, 3'b001);
        run_reject(7'b0110011, 7'b0100000, 3'b011);
        run_reject(7'b0110011, 7'b0000001, 3'b100);
        run_reject(7'b0110011, 7'b0000001, 3'b111);

        // R8: a second start during a run is dropped.
        begin
            int k;
            bit extra;
            @(negedge clk);
            opcode_i = 7'b0110011; funct7_i = 7'b0000001;
            funct3_i = 3'b001; op_a_i = 32'h80000000; op_b_i = 32'h7FFFFFFF; rd_i = 5'd9; start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            k = 1;
            extra = 1'b0;
            while (!done_o && k < LAT + 4) begin
                if (k == 3) begin
                    funct3_i = 3'b000; op_a_i = 32'd7; op_b_i = 32'd9; rd_i = 5'd0; start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(posedge clk);
                @(negedge clk);
                if (!done_o) k++;
            end
            start_i = 1'b0;
            check(k == LAT, "R8 latency unchanged", 64'(k), 64'(LAT));
            check(result_o == 32'hC0000000, "R8 first result kept", 64'(result_o), 64'h00000000C0000000);
            check(wr_en_o == 1'b1, "R8 first rd kept", 64'(wr_en_o), 64'(1));
            for (int i = 0; i < LAT + 3; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (done_o) extra = 1'b1;
            end
            check(!extra, "R8 no second done", 64'(extra), 64'(0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule